// File: doc/BRIEF.md
# Modem control and status unit

This block holds the modem control register and the modem status register of a serial port. The host writes the control register through a small strobe port; its low bits drive the active-low DTR and RTS handshake pins and the two auxiliary outputs OUT1 and OUT2. Another bit selects an internal loopback in which the status side no longer listens to the modem pins and instead sees the unit's own control outputs.

The four active-low modem inputs (CTS, DSR, RI, DCD) pass through a synchronizer. The status register reports their levels in active-high form, together with four sticky change flags. Three of the flags record any change of carrier, data-set-ready and clear-to-send. The fourth records only the end of a ring. A status read returns the register and clears the flags. A one-cycle report request can be raised whenever a new change is captured.

Top module: `modem_ctl_stat`

## Requirements
- R1: A write with `regSel`=0 loads control bits 4:0 from `wrData`. Bits 7:5 of the control register always read as 0. A write with `regSel`=1 changes nothing.
- R2: Control bit 0 set drives `dtrN` low and control bit 1 set drives `rtsN` low. The value 0x08 leaves both high, 0x09 drives only `dtrN` low, and 0x0A drives only `rtsN` low.
- R3: Control bit 2 set drives `out1N` low and control bit 3 set drives `out2N` low.
- R4: Status bits 7, 6, 5 and 4 report the active-high level of carrier detect, ring, data set ready and clear to send. They equal the inverted pin values three clock edges after a pin change, when loopback is off.
- R5: Status bits 3, 1 and 0 set when the carrier, data-set-ready or clear-to-send level changes. They stay set, however many further changes occur, until a status read.
- R6: Status bit 2 sets only when the ring level goes from active to inactive (the `riN` pin going from low to high), never on the opposite edge.
- R7: A status read (`rdEn`=1 with `regSel`=1) returns the current value and clears bits 3:0 at the next edge. A change captured at that same edge is kept set.
- R8: With control bit 4 set, the status levels come from the control bits: CTS from RTS (bit 1), DSR from DTR (bit 0), RI from OUT1 (bit 2) and DCD from OUT2 (bit 3). The modem input pins are ignored.
- R9: Entering or leaving loopback sets the change flag of every status level that differs between the old and the new source, with the R6 rule for ring.
- R10: With `REPORT_EN`=1, `statusReq` is high for exactly the one cycle after an edge at which any change flag event was captured.
- R11: After reset the control register is 0, all four output pins are high, the status register reads 0 with inactive input pins, and `statusReq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regSel | input | 1 | Register select: 0 control, 1 status |
| wrEn | input | 1 | Write strobe |
| rdEn | input | 1 | Read strobe (clears status flags when `regSel`=1) |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data of the selected register |
| ctsN | input | 1 | Clear to send, active low |
| dsrN | input | 1 | Data set ready, active low |
| riN | input | 1 | Ring indicator, active low |
| dcdN | input | 1 | Carrier detect, active low |
| rtsN | output | 1 | Request to send, active low |
| dtrN | output | 1 | Data terminal ready, active low |
| out1N | output | 1 | Auxiliary output 1, active low |
| out2N | output | 1 | Auxiliary output 2, active low |
| statusReq | output | 1 | One-cycle request for a status report |

## Verification
The clear-on-read of the change flags can land on the same edge as a new change arriving from the synchronizer. The bench provokes this by changing a pin, waiting one idle cycle, and then issuing the status read so that the read and the captured change share an edge. A later read without a strobe must still show that flag, while the flags that were set before the read must be gone. A behavioural model with a two-entry queue for the input delay judges this cycle by cycle, and it also judges thousands of random cycles in which reads, writes and pin changes collide freely.

// File: rtl/mcs_pkg.sv
package mcs_pkg;

  // Strobes handed from the access decoder to the datapath
  typedef struct packed {
    logic ctrlWr;   // load control register
    logic statClr;  // status read: clear change flags
  } mcsStrobeT;

  localparam int REG_W = 8;
  localparam int LINE_W = 4;

  // Control bit positions (decoded by the pin drivers and loopback)
  localparam int CB_DTR = 0;
  localparam int CB_RTS = 1;
  localparam int CB_AUX1 = 2;
  localparam int CB_AUX2 = 3;
  localparam int CB_LOOP = 4;
  localparam logic [REG_W-1:0] CTRL_MASK = 8'h1F;

  // Line vector positions, also the order of status bits
  localparam int LN_CTS = 0;
  localparam int LN_DSR = 1;
  localparam int LN_RI = 2;
  localparam int LN_DCD = 3;

endpackage

// File: rtl/mcs_sync.sv
module mcs_sync #(
  parameter int STAGES = 2,
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] dIn,
  output logic [WIDTH-1:0] dOut
);

  logic [WIDTH-1:0] stageQ [STAGES];

  // Each stage resets to all ones (inactive for active-low pins)
  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) stageQ[g] <= '1;
        else       stageQ[g] <= dIn;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) stageQ[g] <= '1;
        else       stageQ[g] <= stageQ[g-1];
      end
    end
  end

  assign dOut = stageQ[STAGES-1];

endmodule

// File: rtl/mcs_access.sv
module mcs_access
  import mcs_pkg::*;
(
  input  logic             regSel,
  input  logic             wrEn,
  input  logic             rdEn,
  input  logic [REG_W-1:0] ctrlVal,
  input  logic [REG_W-1:0] statVal,
  output mcsStrobeT        strobes,
  output logic [REG_W-1:0] rdData
);

  // Only the control register is writable; only a status read has a side effect
  always_comb begin
    strobes.ctrlWr  = wrEn & ~regSel;
    strobes.statClr = rdEn & regSel;
  end

  assign rdData = regSel ? statVal : ctrlVal;

endmodule

// File: rtl/mcs_datapath.sv
module mcs_datapath
  import mcs_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter bit REPORT_EN = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  mcsStrobeT         strobes,
  input  logic [REG_W-1:0]  wrData,
  input  logic [LINE_W-1:0] pinsN,
  output logic [REG_W-1:0]  ctrlVal,
  output logic [REG_W-1:0]  statVal,
  output logic              evtAny,
  output logic              statusReq,
  output logic              rtsN,
  output logic              dtrN,
  output logic              out1N,
  output logic              out2N
);

  logic [REG_W-1:0]  ctrlQ;
  logic [LINE_W-1:0] pinsSyncN;
  logic [LINE_W-1:0] loopSrc;
  logic [LINE_W-1:0] lineNext;
  logic [LINE_W-1:0] lineQ;
  logic [LINE_W-1:0] evt;
  logic [LINE_W-1:0] deltaQ;

  // Control register; reserved bits are masked so they stay zero
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               ctrlQ <= '0;
    else if (strobes.ctrlWr) ctrlQ <= wrData & CTRL_MASK;
  end

  assign dtrN  = ~ctrlQ[CB_DTR];
  assign rtsN  = ~ctrlQ[CB_RTS];
  assign out1N = ~ctrlQ[CB_AUX1];
  assign out2N = ~ctrlQ[CB_AUX2];

  mcs_sync #(
    .STAGES(SYNC_STAGES),
    .WIDTH (LINE_W)
  ) u_sync (
    .clk (clk),
    .rstN(rstN),
    .dIn (pinsN),
    .dOut(pinsSyncN)
  );

  // Loopback wiring of the control outputs onto the status lines
  always_comb begin
    loopSrc         = '0;
    loopSrc[LN_CTS] = ctrlQ[CB_RTS];
    loopSrc[LN_DSR] = ctrlQ[CB_DTR];
    loopSrc[LN_RI]  = ctrlQ[CB_AUX1];
    loopSrc[LN_DCD] = ctrlQ[CB_AUX2];
  end

  // One registered mux: the level only ever moves at a clock edge
  assign lineNext = ctrlQ[CB_LOOP] ? loopSrc : ~pinsSyncN;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) lineQ <= '0;
    else       lineQ <= lineNext;
  end

  // Change events: any toggle, except ring which only counts its end
  always_comb begin
    evt         = lineQ ^ lineNext;
    evt[LN_RI]  = lineQ[LN_RI] & ~lineNext[LN_RI];
  end

  assign evtAny = |evt;

  // A fresh event wins over the clear of the same edge
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                deltaQ <= '0;
    else if (strobes.statClr) deltaQ <= evt;
    else                      deltaQ <= deltaQ | evt;
  end

  if (REPORT_EN) begin : g_report
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) statusReq <= 1'b0;
      else       statusReq <= evtAny;
    end
  end else begin : g_no_report
    assign statusReq = 1'b0;
  end

  assign ctrlVal = ctrlQ;
  assign statVal = {lineQ, deltaQ};

endmodule

// File: rtl/modem_ctl_stat.sv
module modem_ctl_stat
  import mcs_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter bit REPORT_EN = 1'b1
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       regSel,
  input  logic       wrEn,
  input  logic       rdEn,
  input  logic [7:0] wrData,
  output logic [7:0] rdData,
  input  logic       ctsN,
  input  logic       dsrN,
  input  logic       riN,
  input  logic       dcdN,
  output logic       rtsN,
  output logic       dtrN,
  output logic       out1N,
  output logic       out2N,
  output logic       statusReq
);

  mcsStrobeT        strobes;
  logic [REG_W-1:0] ctrlVal;
  logic [REG_W-1:0] statVal;
  logic             evtAny;
  logic [LINE_W-1:0] pinsN;

  assign pinsN = {dcdN, riN, dsrN, ctsN};

  mcs_access u_access (
    .regSel (regSel),
    .wrEn   (wrEn),
    .rdEn   (rdEn),
    .ctrlVal(ctrlVal),
    .statVal(statVal),
    .strobes(strobes),
    .rdData (rdData)
  );

  mcs_datapath #(
    .SYNC_STAGES(SYNC_STAGES),
    .REPORT_EN  (REPORT_EN)
  ) u_datapath (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .wrData   (wrData),
    .pinsN    (pinsN),
    .ctrlVal  (ctrlVal),
    .statVal  (statVal),
    .evtAny   (evtAny),
    .statusReq(statusReq),
    .rtsN     (rtsN),
    .dtrN     (dtrN),
    .out1N    (out1N),
    .out2N    (out2N)
  );

endmodule

// File: rtl/mcs_checker.sv
module mcs_checker (
  input logic       clk,
  input logic       rstN,
  input logic       regSel,
  input logic       wrEn,
  input logic       rdEn,
  input logic [3:0] wrLow,
  input logic [7:0] rdData,
  input logic [7:0] statVal,
  input logic       evtAny,
  input logic       dtrN,
  input logic       rtsN,
  input logic       out1N,
  input logic       out2N,
  input logic       statusReq
);

  // R1
  ctrl_reserved_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    !regSel |-> (rdData[7:5] == 3'b000));

  // R4
  stat_readback_chk: assert property (@(posedge clk) disable iff (!rstN)
    regSel |-> (rdData == statVal));

  // R2
  hs_pins_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !regSel) |=> (dtrN == !$past(wrLow[0]) && rtsN == !$past(wrLow[1])));

  // R3
  aux_pins_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !regSel) |=> (out1N == !$past(wrLow[2]) && out2N == !$past(wrLow[3])));

  // R5
  dcd_delta_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(statVal[3]) |-> (statVal[7] != $past(statVal[7])));

  // R5
  dsr_delta_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(statVal[1]) |-> (statVal[5] != $past(statVal[5])));

  // R5
  cts_delta_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(statVal[0]) |-> (statVal[4] != $past(statVal[4])));

  // R5
  delta_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!(rdEn && regSel) && statVal[0]) |=> statVal[0]);

  // R6
  ring_trailing_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(statVal[2]) |-> ($past(statVal[6]) && !statVal[6]));

  // R7
  read_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && regSel) |=> ((statVal[3:0] == 4'b0000) || $past(evtAny)));

  // R10
  report_has_delta_chk: assert property (@(posedge clk) disable iff (!rstN)
    statusReq |-> (statVal[3:0] != 4'b0000));

endmodule

bind modem_ctl_stat mcs_checker u_checker (
  .clk      (clk),
  .rstN     (rstN),
  .regSel   (regSel),
  .wrEn     (wrEn),
  .rdEn     (rdEn),
  .wrLow    (wrData[3:0]),
  .rdData   (rdData),
  .statVal  (statVal),
  .evtAny   (evtAny),
  .dtrN     (dtrN),
  .rtsN     (rtsN),
  .out1N    (out1N),
  .out2N    (out2N),
  .statusReq(statusReq)
);

// File: tb/test_modem_ctl_stat.sv
module test_modem_ctl_stat;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       regSel = 1'b0;
  logic       wrEn = 1'b0;
  logic       rdEn = 1'b0;
  logic [7:0] wrData = 8'h00;
  logic [7:0] rdData;
  logic [3:0] pinBus = 4'hF;   // {dcdN, riN, dsrN, ctsN}
  logic       rtsN, dtrN, out1N, out2N, statusReq;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  modem_ctl_stat i_modem_ctl_stat (
    .clk      (clk),
    .rstN     (rstN),
    .regSel   (regSel),
    .wrEn     (wrEn),
    .rdEn     (rdEn),
    .wrData   (wrData),
    .rdData   (rdData),
    .ctsN     (pinBus[0]),
    .dsrN     (pinBus[1]),
    .riN      (pinBus[2]),
    .dcdN     (pinBus[3]),
    .rtsN     (rtsN),
    .dtrN     (dtrN),
    .out1N    (out1N),
    .out2N    (out2N),
    .statusReq(statusReq)
  );

  // ---------------- reference model ----------------
  logic [4:0] mCtrl;
  logic [3:0] mLvl;     // {dcd, ri, dsr, cts} active high
  logic [3:0] mDelta;
  bit         mReq;
  logic [3:0] pinQ[$];  // pin samples still in flight

  always @(posedge clk) begin
    logic [3:0] nxt;
    logic [3:0] ev;
    if (!rstN) begin
      mCtrl = '0; mLvl = '0; mDelta = '0; mReq = 0;
      pinQ = '{4'hF, 4'hF};
    end else begin
      if (mCtrl[4]) nxt = {mCtrl[3], mCtrl[2], mCtrl[0], mCtrl[1]};
      else          nxt = ~pinQ[0];
      ev[3] = (nxt[3] != mLvl[3]);
      ev[2] = mLvl[2] && !nxt[2];
      ev[1] = (nxt[1] != mLvl[1]);
      ev[0] = (nxt[0] != mLvl[0]);
      if (rdEn && regSel) mDelta = ev;
      else                mDelta = mDelta | ev;
      mReq = (ev != 4'b0000);
      mLvl = nxt;
      if (wrEn && !regSel) mCtrl = wrData[4:0];
      void'(pinQ.pop_front());
      pinQ.push_back(pinBus);
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s at %0t: actual %02h expected %02h", tag, $time, act, exp);
    end
  endtask

  // Per-cycle comparison, 8 ns after each rising edge
  always begin
    @(posedge clk);
    #8;
    if (rstN && !finished) begin
      if (regSel) begin
        chk(rdData[7:4] == (mCtrl[4] ? mLvl : mLvl), mCtrl[4] ? "R8 loop levels" : "R4 levels",
            {4'h0, rdData[7:4]}, {4'h0, mLvl});
        chk({rdData[3], rdData[1:0]} == {mDelta[3], mDelta[1:0]}, "R5 change flags",
            {4'h0, rdData[3:0]}, {4'h0, mDelta});
        chk(rdData[2] == mDelta[2], "R6 ring flag", {7'h0, rdData[2]}, {7'h0, mDelta[2]});
      end else begin
        chk(rdData == {3'b000, mCtrl}, "R1 control readback", rdData, {3'b000, mCtrl});
      end
      chk({dtrN, rtsN} == ~{mCtrl[0], mCtrl[1]}, "R2 handshake pins",
          {6'h0, dtrN, rtsN}, {6'h0, ~mCtrl[0], ~mCtrl[1]});
      chk({out1N, out2N} == ~{mCtrl[2], mCtrl[3]}, "R3 aux pins",
          {6'h0, out1N, out2N}, {6'h0, ~mCtrl[2], ~mCtrl[3]});
      chk(statusReq == mReq, "R10 report pulse", {7'h0, statusReq}, {7'h0, mReq});
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      wrEn = 0; rdEn = 0;
    end
  endtask

  task automatic wrCtrl(input logic [7:0] v);
    @(negedge clk);
    regSel = 0; wrEn = 1; rdEn = 0; wrData = v;
  endtask

  task automatic rdStat();
    @(negedge clk);
    regSel = 1; wrEn = 0; rdEn = 1;
  endtask

  task automatic setPins(input logic [3:0] v);
    @(negedge clk);
    wrEn = 0; rdEn = 0; pinBus = v;
  endtask

  task automatic peek(input bit sel, output logic [7:0] v);
    @(negedge clk);
    regSel = sel; wrEn = 0; rdEn = 0;
    #3 v = rdData;
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (60000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      errors++;
      $display("FAIL watchdog: run did not complete");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  // ---------------- directed and random sequences ----------------
  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rstN = 1;

    // R11 reset state
    peek(0, v); chk(v == 8'h00, "R11 control after reset", v, 8'h00);
    chk({dtrN, rtsN, out1N, out2N} == 4'hF, "R11 pins after reset", {4'h0, dtrN, rtsN, out1N, out2N}, 8'h0F);
    chk(statusReq == 0, "R11 no report after reset", {7'h0, statusReq}, 8'h00);
    peek(1, v); chk(v == 8'h00, "R11 status after reset", v, 8'h00);

    // R2 encodings
    wrCtrl(8'h08); idle(1);
    chk({dtrN, rtsN, out2N} == 3'b110, "R2 code 08", {5'h0, dtrN, rtsN, out2N}, 8'h06);
    wrCtrl(8'h09); idle(1);
    chk({dtrN, rtsN} == 2'b01, "R2 code 09", {6'h0, dtrN, rtsN}, 8'h01);
    wrCtrl(8'h0A); idle(1);
    chk({dtrN, rtsN} == 2'b10, "R2 code 0A", {6'h0, dtrN, rtsN}, 8'h02);
    // R3 aux outputs
    wrCtrl(8'h04); idle(1);
    chk({out1N, out2N} == 2'b01, "R3 aux1 only", {6'h0, out1N, out2N}, 8'h01);
    // R1 reserved bits and ignored status write
    wrCtrl(8'hE3); peek(0, v); chk(v == 8'h03, "R1 reserved bits", v, 8'h03);
    @(negedge clk); regSel = 1; wrEn = 1; wrData = 8'hFF;
    peek(0, v); chk(v == 8'h03, "R1 status write ignored", v, 8'h03);
    wrCtrl(8'h00); idle(2);

    // R7 read coinciding with a new change
    rdStat(); idle(3);
    setPins(4'hE); idle(1); rdStat();
    peek(1, v); chk(v == 8'h11, "R7 change kept over read", v, 8'h11);
    rdStat(); peek(1, v); chk(v == 8'h10, "R7 flags cleared", v, 8'h10);

    // R6 ring: leading edge ignored, trailing edge flagged
    setPins(4'hA); idle(4); rdStat();
    peek(1, v); chk(v == 8'h50, "R6 ring start not flagged", v, 8'h50);
    setPins(4'hE); idle(4);
    peek(1, v); chk(v == 8'h14, "R6 ring end flagged", v, 8'h14);

    // R5 several toggles give one sticky flag
    setPins(4'hC); setPins(4'hE); setPins(4'hC); setPins(4'hE); idle(4);
    peek(1, v); chk(v == 8'h16, "R5 sticky dsr flag", v, 8'h16);
    rdStat(); peek(1, v); chk(v == 8'h10, "R5 cleared by read", v, 8'h10);

    // R8 and R9 loopback
    wrCtrl(8'h10); idle(1);
    peek(1, v); chk(v == 8'h01, "R9 entering loopback", v, 8'h01);
    rdStat(); setPins(4'h0); idle(4);
    peek(1, v); chk(v == 8'h00, "R8 pins ignored in loopback", v, 8'h00);
    wrCtrl(8'h1F); idle(1);
    peek(1, v); chk(v == 8'hFB, "R8 loop all active", v, 8'hFB);
    rdStat(); wrCtrl(8'h10); idle(1);
    peek(1, v); chk(v == 8'h0F, "R8 loop all inactive", v, 8'h0F);
    rdStat(); wrCtrl(8'h00); idle(1);
    peek(1, v); chk(v == 8'hFB, "R9 leaving loopback", v, 8'hFB);
    rdStat(); setPins(4'hF); idle(4); rdStat(); idle(2);

    // Random mix of pin changes, writes and reads
    for (int i = 0; i < 4000; i++) begin
      int r;
      @(negedge clk);
      r = $urandom_range(0, 99);
      if (r < 12) pinBus[$urandom_range(0, 3)] ^= 1'b1;
      r = $urandom_range(0, 99);
      wrEn = 0; rdEn = 0;
      if (r < 8) begin
        regSel = 0; wrEn = 1; wrData = 8'($urandom);
      end else if (r < 22) begin
        regSel = 1; rdEn = 1;
      end else if (r < 25) begin
        regSel = 1; wrEn = 1; wrData = 8'($urandom);
      end else begin
        regSel = r[0];
      end
    end
    idle(4);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule